// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox

This block passes single bytes between an external host bus and a local slave processor. The host writes an inbound data register and reads either an outbound data register or a status byte. The slave reads the inbound register, writes the outbound register and maintains the status byte. Two handshake flags in the status byte tell each side when a byte is waiting: outbound-full and inbound-full. A command/data flag records which of the channel's two host addresses the host used for its last write. The slave uses this flag to tell commands from data.

The host port uses parallel strobes. A small access state machine turns each strobe into exactly one action, however long the host holds it. `HST_IDLE` moves to `HST_RD_HOLD` on a new read strobe, or to `HST_WR_HOLD` on a new write strobe; write wins if both strobes are asserted. Each hold state returns to `HST_IDLE` once its strobe, or the channel select, is released. The read or write action happens only on the transition out of `HST_IDLE`.

Status byte layout:
- bit 0: outbound-full
- bit 1: inbound-full
- bit 3: command/data
- bits 7:4 and 2: free bits for the slave's own use

Host address decode: the channel answers at `CHAN_BASE` and at `CHAN_BASE` with bit 2 set. Bit 2 clear is the data address; bit 2 set is the status/command address. The slave's register address is 0 for inbound, 1 for outbound and 2 for status.

Top module: `hsmbox_top`

## Requirements
- R1: After reset the status byte, the inbound register and the outbound register all read 0.
- R2: A slave write to the outbound register stores the byte, which the host then reads at the data address, and sets outbound-full (bit 0) at the next clock edge.
- R3: A host read at the data address clears outbound-full at the next edge; a host read at the status address leaves it unchanged.
- R4: A slave write to the status byte with bit 0 at 0 clears outbound-full; with bit 0 at 1 it leaves outbound-full unchanged.
- R5: A host write stores the byte in the inbound register and copies address bit 2 into command/data (bit 3): 0 marks data, 1 marks a command.
- R6: Slave status writes change neither command/data nor inbound-full.
- R7: The free bits (7:4 and 2) take the slave's written value and are never changed by host writes.
- R8: A host write sets inbound-full (bit 1); a slave read of the inbound register clears it.
- R9: If a slave outbound write and a host data-address read fall in the same cycle, outbound-full ends at 1.
- R10: A host strobe held over several cycles acts only in its first cycle; a new action needs the strobe to drop first.
- R11: With read and write strobes asserted together, only the write takes effect.
- R12: Host accesses whose address, bit 2 aside, differs from `CHAN_BASE` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host channel select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HADDR_W | Host I/O address |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte (combinational; status at bit-2 address, outbound otherwise) |
| sl_sel | input | 1 | Slave access select |
| sl_we | input | 1 | Slave write enable |
| sl_re | input | 1 | Slave read enable (clears inbound-full on inbound reads) |
| sl_addr | input | 2 | Slave register address: 0 inbound, 1 outbound, 2 status |
| sl_wdata | input | DATA_W | Slave write byte |
| sl_rdata | output | DATA_W | Slave read byte (combinational) |

## Verification
Every flag and register change lands on the first rising edge that sees the strobe, because the action decode is combinational from the idle state. Both read buses are combinational and show the new state in the same cycle. The bench therefore drives a stimulus at a falling edge and releases it at the next falling edge. It lets one more edge return the access machine to idle, then samples the status byte at the falling edge after that. For the held-strobe and collision cases, the bench instead samples at the falling edge directly after each active edge.

// File: rtl/hsmbox_pkg.sv
package hsmbox_pkg;
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int CD_BIT  = 3;
    localparam int SL_AW   = 2;

    typedef enum logic [1:0] {
        HST_IDLE    = 2'd0,
        HST_RD_HOLD = 2'd1,
        HST_WR_HOLD = 2'd2
    } hst_state_e;

    typedef enum logic [SL_AW-1:0] {
        SL_IDR  = 2'd0,
        SL_ODR  = 2'd1,
        SL_STAT = 2'd2,
        SL_NONE = 2'd3
    } sl_reg_e;
endpackage

// File: rtl/hsmbox_host_fsm.sv
module hsmbox_host_fsm
    import hsmbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd,
    input  logic wr,
    output logic rd_evt,
    output logic wr_evt
);
    hst_state_e state_q, state_d;
    logic rd_act, wr_act;

    assign rd_act = hit && rd;
    assign wr_act = hit && wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HST_IDLE: begin
                if (wr_act)      state_d = HST_WR_HOLD;
                else if (rd_act) state_d = HST_RD_HOLD;
            end
            HST_RD_HOLD: if (!rd_act) state_d = HST_IDLE;
            HST_WR_HOLD: if (!wr_act) state_d = HST_IDLE;
            default:     state_d = HST_IDLE;
        endcase
    end

    always_comb begin
        rd_evt = 1'b0;
        wr_evt = 1'b0;
        unique case (state_q)
            HST_IDLE: begin
                wr_evt = wr_act;
                rd_evt = rd_act && !wr_act;
            end
            HST_RD_HOLD, HST_WR_HOLD: begin
                rd_evt = 1'b0;
                wr_evt = 1'b0;
            end
            default: begin
                rd_evt = 1'b0;
                wr_evt = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hsmbox_regs.sv
module hsmbox_regs
    import hsmbox_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] USER_MASK = 8'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_evt,
    input  logic              host_rd_evt,
    input  logic              host_stat_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              sl_sel,
    input  logic              sl_we,
    input  logic              sl_re,
    input  logic [SL_AW-1:0]  sl_addr,
    input  logic [DATA_W-1:0] sl_wdata,
    output logic [DATA_W-1:0] idr_q,
    output logic [DATA_W-1:0] odr_q,
    output logic [DATA_W-1:0] status
);
    localparam logic [DATA_W-1:0] FLAG_MASK =
        DATA_W'((1 << OBF_BIT) | (1 << IBF_BIT) | (1 << CD_BIT));
    localparam logic [DATA_W-1:0] FREE_MASK = USER_MASK & ~FLAG_MASK;

    logic              obf_q, ibf_q, cd_q;
    logic              obf_d, ibf_d;
    logic [DATA_W-1:0] user_q;
    logic              sl_odr_wr, sl_stat_wr, sl_idr_rd, host_odr_rd;

    assign sl_odr_wr   = sl_sel && sl_we && (sl_addr == SL_ODR);
    assign sl_stat_wr  = sl_sel && sl_we && (sl_addr == SL_STAT);
    assign sl_idr_rd   = sl_sel && sl_re && (sl_addr == SL_IDR);
    assign host_odr_rd = host_rd_evt && !host_stat_sel;

    always_comb begin
        obf_d = obf_q;
        if (sl_odr_wr)                                 obf_d = 1'b1;
        else if (host_odr_rd)                          obf_d = 1'b0;
        else if (sl_stat_wr && !sl_wdata[OBF_BIT])     obf_d = 1'b0;
    end

    always_comb begin
        ibf_d = ibf_q;
        if (host_wr_evt)    ibf_d = 1'b1;
        else if (sl_idr_rd) ibf_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obf_q  <= 1'b0;
            ibf_q  <= 1'b0;
            cd_q   <= 1'b0;
            user_q <= '0;
            idr_q  <= '0;
            odr_q  <= '0;
        end else begin
            obf_q <= obf_d;
            ibf_q <= ibf_d;
            if (host_wr_evt) begin
                idr_q <= host_wdata;
                cd_q  <= host_stat_sel;
            end
            if (sl_odr_wr)  odr_q  <= sl_wdata;
            if (sl_stat_wr) user_q <= sl_wdata & FREE_MASK;
        end
    end

    always_comb begin
        status          = user_q & FREE_MASK;
        status[OBF_BIT] = obf_q;
        status[IBF_BIT] = ibf_q;
        status[CD_BIT]  = cd_q;
    end
endmodule

// File: rtl/hsmbox_top.sv
module hsmbox_top
    import hsmbox_pkg::*;
#(
    parameter int                 DATA_W    = 8,
    parameter int                 HADDR_W   = 4,
    parameter int                 SEL_BIT   = 2,
    parameter logic [HADDR_W-1:0] CHAN_BASE = 4'h2,
    parameter logic [DATA_W-1:0]  USER_MASK = 8'hF4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               sl_sel,
    input  logic               sl_we,
    input  logic               sl_re,
    input  logic [1:0]         sl_addr,
    input  logic [DATA_W-1:0]  sl_wdata,
    output logic [DATA_W-1:0]  sl_rdata
);
    localparam logic [HADDR_W-1:0] SEL_MASK = HADDR_W'(1) << SEL_BIT;

    logic              host_hit, host_rd_evt, host_wr_evt, host_stat_sel;
    logic [DATA_W-1:0] idr_w, odr_w, status_w;

    assign host_hit      = host_cs && ((host_addr & ~SEL_MASK) == (CHAN_BASE & ~SEL_MASK));
    assign host_stat_sel = host_addr[SEL_BIT];

    hsmbox_host_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (host_hit),
        .rd     (host_rd),
        .wr     (host_wr),
        .rd_evt (host_rd_evt),
        .wr_evt (host_wr_evt)
    );

    hsmbox_regs #(
        .DATA_W    (DATA_W),
        .USER_MASK (USER_MASK)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_evt   (host_wr_evt),
        .host_rd_evt   (host_rd_evt),
        .host_stat_sel (host_stat_sel),
        .host_wdata    (host_wdata),
        .sl_sel        (sl_sel),
        .sl_we         (sl_we),
        .sl_re         (sl_re),
        .sl_addr       (sl_addr),
        .sl_wdata      (sl_wdata),
        .idr_q         (idr_w),
        .odr_q         (odr_w),
        .status        (status_w)
    );

    always_comb begin
        if (!host_hit)          host_rdata = '0;
        else if (host_stat_sel) host_rdata = status_w;
        else                    host_rdata = odr_w;
    end

    always_comb begin
        unique case (sl_reg_e'(sl_addr))
            SL_IDR:  sl_rdata = idr_w;
            SL_ODR:  sl_rdata = odr_w;
            SL_STAT: sl_rdata = status_w;
            default: sl_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hsmbox_chk.sv
module hsmbox_chk
    import hsmbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sl_sel,
    input logic              sl_we,
    input logic [1:0]        sl_addr,
    input logic              sl_w_obf,
    input logic              host_stat_sel,
    input logic              host_rd_evt,
    input logic              host_wr_evt,
    input logic [DATA_W-1:0] status
);
    logic sl_odr_wr, sl_stat_wr;
    assign sl_odr_wr  = sl_sel && sl_we && (sl_addr == SL_ODR);
    assign sl_stat_wr = sl_sel && sl_we && (sl_addr == SL_STAT);

    // R2
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sl_odr_wr |=> status[OBF_BIT]);

    // R3
    obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_evt && !host_stat_sel && !sl_odr_wr) |=> !status[OBF_BIT]);

    // R4
    obf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_stat_wr && sl_w_obf && !host_rd_evt) |=> $stable(status[OBF_BIT]));

    // R5
    cd_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_evt |=> (status[CD_BIT] == $past(host_stat_sel)));

    // R6
    cd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr_evt |=> $stable(status[CD_BIT]));

    // R8
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_evt |=> status[IBF_BIT]);

    // R10
    one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_evt |=> !host_rd_evt);

    // R10
    one_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_evt |=> !host_wr_evt);

    // R11
    excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_rd_evt, host_wr_evt}));
endmodule

bind hsmbox_top hsmbox_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sl_sel        (sl_sel),
    .sl_we         (sl_we),
    .sl_addr       (sl_addr),
    .sl_w_obf      (sl_wdata[0]),
    .host_stat_sel (host_stat_sel),
    .host_rd_evt   (host_rd_evt),
    .host_wr_evt   (host_wr_evt),
    .status        (status_w)
);

// File: tb/hsmbox_top_tb.sv
`timescale 1ns/1ps
module hsmbox_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [3:0] host_addr = 4'h2;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       sl_sel = 1'b0, sl_we = 1'b0, sl_re = 1'b0;
    logic [1:0] sl_addr = 2'd2;
    logic [7:0] sl_wdata = '0;
    logic [7:0] sl_rdata;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    hsmbox_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sl_sel(sl_sel), .sl_we(sl_we), .sl_re(sl_re),
        .sl_addr(sl_addr), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata)
    );

    // op: 0 slave outbound write, 1 slave status write, 2 host write,
    //     3 host read, 4 slave inbound read
    // fields: {op[2:0], host_addr[3:0], data[7:0], expected status[7:0]}
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {3'd0, 4'h2, 8'hA5, 8'h01},  // R2 set outbound-full
        {3'd3, 4'h6, 8'h00, 8'h01},  // R3 status read keeps it
        {3'd3, 4'h2, 8'h00, 8'h00},  // R3 data read clears it
        {3'd2, 4'h2, 8'h3C, 8'h02},  // R5 R8 data write
        {3'd2, 4'h6, 8'h7E, 8'h0A},  // R5 command write
        {3'd4, 4'h2, 8'h00, 8'h08},  // R8 slave read clears inbound-full
        {3'd1, 4'h2, 8'hFF, 8'hFC},  // R4 R6 R7 ones written
        {3'd0, 4'h2, 8'h11, 8'hFD},  // R2
        {3'd1, 4'h2, 8'hFE, 8'hFC},  // R4 zero clears
        {3'd0, 4'h2, 8'h22, 8'hFD},  // R2
        {3'd1, 4'h2, 8'h01, 8'h09},  // R4 R7 one keeps, free bits cleared
        {3'd2, 4'h2, 8'h55, 8'h03},  // R5 R7 data write
        {3'd3, 4'h2, 8'h00, 8'h02}   // R3
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_cs = 1'b0; host_rd = 1'b0; host_wr = 1'b0; host_addr = 4'h2;
        sl_sel = 1'b0; sl_we = 1'b0; sl_re = 1'b0; sl_addr = 2'd2;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        case (op)
            3'd0: begin sl_sel = 1; sl_we = 1; sl_addr = 2'd1; sl_wdata = d; end
            3'd1: begin sl_sel = 1; sl_we = 1; sl_addr = 2'd2; sl_wdata = d; end
            3'd2: begin host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d; end
            3'd3: begin host_cs = 1; host_rd = 1; host_addr = a; end
            default: begin sl_sel = 1; sl_re = 1; sl_addr = 2'd0; end
        endcase
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", sl_rdata, 8'h00);
        sl_addr = 2'd0; #1 check("R1 inbound", sl_rdata, 8'h00);
        sl_addr = 2'd1; #1 check("R1 outbound", sl_rdata, 8'h00);
        sl_addr = 2'd2;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][22:20], VEC[i][19:16], VEC[i][15:8]);
            check($sformatf("vector %0d status R2-R8", i), sl_rdata, VEC[i][7:0]);
        end

        // R2 host sees the outbound byte at the data address
        host_cs = 1; host_addr = 4'h2; #1
        check("R2 host data", host_rdata, 8'h22);
        host_addr = 4'h6; #1
        check("R3 host status view", host_rdata, 8'h02);
        idle_inputs();
        // R5 inbound byte
        sl_addr = 2'd0; #1 check("R5 inbound byte", sl_rdata, 8'h55);
        sl_addr = 2'd2;

        // R12 foreign address ignored: write at 0x0, read at 0x4
        run_op(3'd4, 4'h2, 8'h00);                 // clear inbound-full
        run_op(3'd2, 4'h0, 8'hEE);
        check("R12 write ignored status", sl_rdata, 8'h00);
        sl_addr = 2'd0; #1 check("R12 inbound untouched", sl_rdata, 8'h55);
        sl_addr = 2'd2;
        run_op(3'd0, 4'h2, 8'h66);
        run_op(3'd3, 4'h4, 8'h00);
        check("R12 read ignored", sl_rdata, 8'h01);

        // R10 held read acts once
        run_op(3'd1, 4'h2, 8'h00);                 // clear outbound-full
        @(negedge clk);
        host_cs = 1; host_rd = 1; host_addr = 4'h2;
        @(negedge clk);
        sl_sel = 1; sl_we = 1; sl_addr = 2'd1; sl_wdata = 8'h77;
        @(negedge clk);
        sl_sel = 0; sl_we = 0; sl_addr = 2'd2;
        @(negedge clk);
        #1 check("R10 held read no reclear", sl_rdata[0], 1'b1);
        host_rd = 0;
        @(negedge clk);
        host_rd = 1;
        @(negedge clk);
        host_rd = 0; host_cs = 0;
        #1 check("R10 fresh read clears", sl_rdata[0], 1'b0);
        @(negedge clk);

        // R9 same-cycle set and clear
        host_cs = 1; host_rd = 1; host_addr = 4'h2;
        sl_sel = 1; sl_we = 1; sl_addr = 2'd1; sl_wdata = 8'h99;
        @(negedge clk);
        idle_inputs();
        #1 check("R9 set wins", sl_rdata[0], 1'b1);
        host_cs = 1; #1 check("R9 outbound byte", host_rdata, 8'h99);
        host_cs = 0;
        @(negedge clk);

        // R11 both strobes: write only
        host_cs = 1; host_rd = 1; host_wr = 1; host_addr = 4'h6; host_wdata = 8'h33;
        @(negedge clk);
        idle_inputs();
        #1 check("R11 write taken", sl_rdata & 8'h0B, 8'h0B);
        sl_addr = 2'd0; #1 check("R11 inbound byte", sl_rdata, 8'h33);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule